// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the combinational byte-wide arithmetic and logic stage of a small accumulator machine. Each evaluation takes the current accumulator, a second operand and the present flag byte. A 3-bit operation code picks the operation. The code is the middle field, bits 5:3, of both the register-source and the immediate ALU instruction groups. The block returns the result byte, a strobe that says whether the accumulator should take the result, and a fresh set of four condition flags.

Eight operations are provided: plain add, add with carry-in, subtract, subtract with borrow-in, bitwise AND, XOR and OR, and compare. Compare produces the flags of a subtraction but leaves the accumulator alone. Fetching the operand from a register, from memory or from the instruction stream is the job of the surrounding datapath, and so is writing the flags back. On write-back the four flags form the upper nibble of the flag byte and the lower nibble is zero.

Top module: `alu8_acc_unit`

## Requirements
- R1: `op_sel_i` encodes the operation as 0=add, 1=add with carry, 2=subtract, 3=subtract with borrow, 4=AND, 5=XOR, 6=OR, 7=compare.
- R2: Add returns (A+B) mod 256 and clears the subtract flag. Carry is set when A+B exceeds 255. Half-carry is set when A[3:0]+B[3:0] exceeds 15.
- R3: Add with carry uses the carry flag (bit 4 of `flags_i`) as the carry-in. The result is (A+B+cin) mod 256. Half-carry is set when A[3:0]+B[3:0]+cin exceeds 15, and carry is set when A+B+cin exceeds 255.
- R4: Subtract returns (A−B) mod 256 and sets the subtract flag. Carry is set when A<B, and half-carry is set when A[3:0]<B[3:0].
- R5: Subtract with borrow returns (A−B−cin) mod 256 and sets the subtract flag. Carry is set when A<B+cin, and half-carry is set when A[3:0]<B[3:0]+cin. For example, A−A−1 gives 0xFF with subtract, half-carry and carry all set.
- R6: AND returns A&B, sets half-carry and clears subtract and carry.
- R7: XOR and OR return A^B and A|B and clear subtract, half-carry and carry.
- R8: The zero flag is set exactly when the 8-bit outcome is zero. For compare, the outcome is the difference A−B.
- R9: Compare drives `res_we_o` low and returns the accumulator unchanged on `res_o`. Its flags equal those of subtract on the same operands. Every other operation drives `res_we_o` high.
- R10: `flags_o` is ordered {zero, subtract, half-carry, carry}, which is bits 7..4 of the flag byte. Every bit of `flags_i` other than bit 4 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| flags_i | input | 8 | Current flag byte; only bit 4 (carry) is used |
| op_sel_i | input | 3 | Operation code (opcode bits 5:3) |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | High when the accumulator should take `res_o` |
| flags_o | output | 4 | New flags {zero, subtract, half-carry, carry} |

## Verification
Compare is the case where two functions act in the same evaluation. The subtract path must produce correct zero, half-carry and carry flags, while the result path must still present the untouched accumulator with the write strobe low. The bench drives compare with equal operands, with operands that differ only in the low nibble, and with random operands. It checks all three outputs together against a model that derives the flags from a subtraction and the result from the accumulator. A second overlap is in subtract with borrow when the operands are equal. There the carry-in alone decides whether both borrows appear, so equal operands are applied with the carry flag both clear and set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned ALU_W  = 8;
  localparam int unsigned HALF_W = 4;
  localparam int unsigned CARRY_BIT = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logic_fn_e;

  typedef struct packed {
    logic      use_arith;
    logic      sub_mode;
    logic      use_cin;
    logic      write_res;
    logic_fn_e lfn;
  } alu_ctrl_t;
endpackage

// File: rtl/alu8_op_decode.sv
module alu8_op_decode
  import alu8_pkg::*;
(
  input  logic [2:0] op_sel_i,
  output alu_ctrl_t  ctrl_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_sel_i);

  always_comb begin
    ctrl_o.use_arith = ~op_sel_i[2] | (op == OP_CMP);
    ctrl_o.sub_mode  = (op == OP_SUB) | (op == OP_SBC) | (op == OP_CMP);
    ctrl_o.use_cin   = (op == OP_ADC) | (op == OP_SBC);
    ctrl_o.write_res = (op != OP_CMP);
    unique case (op)
      OP_XOR:  ctrl_o.lfn = LG_XOR;
      OP_OR:   ctrl_o.lfn = LG_OR;
      default: ctrl_o.lfn = LG_AND;
    endcase
  end

  always_comb begin
    if (op == OP_CMP)
      assert_cmp_no_write_R9: assert (!ctrl_o.write_res && ctrl_o.sub_mode && !ctrl_o.use_cin);
    if (op_sel_i[2] && op != OP_CMP)
      assert_logic_route_R1: assert (!ctrl_o.use_arith && !ctrl_o.sub_mode);
  end
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int unsigned DATA_W = alu8_pkg::ALU_W,
  parameter int unsigned HALF_W = alu8_pkg::HALF_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  input  logic              use_cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              half_o,
  output logic              carry_o
);
  localparam int unsigned FULL_W = DATA_W + 1;
  localparam int unsigned LOW_W  = HALF_W + 1;

  function automatic logic [FULL_W-1:0] wide_sum(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y,
                                                 input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  function automatic logic [LOW_W-1:0] low_sum(input logic [HALF_W-1:0] x,
                                               input logic [HALF_W-1:0] y,
                                               input logic ci);
    return {1'b0, x} + {1'b0, y} + {{HALF_W{1'b0}}, ci};
  endfunction

  logic [DATA_W-1:0] b_eff;
  logic              ci_raw, ci_eff;
  logic [FULL_W-1:0] full;
  logic [LOW_W-1:0]  low;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign ci_raw = use_cin_i & cin_i;
  assign ci_eff = sub_i ? ~ci_raw : ci_raw;
  assign full   = wide_sum(a_i, b_eff, ci_eff);
  assign low    = low_sum(a_i[HALF_W-1:0], b_eff[HALF_W-1:0], ci_eff);

  assign res_o   = full[DATA_W-1:0];
  assign zero_o  = (full[DATA_W-1:0] == '0);
  assign carry_o = full[DATA_W] ^ sub_i;
  assign half_o  = low[HALF_W] ^ sub_i;

  always_comb begin
    if (sub_i && !use_cin_i)
      assert_sub_borrow_R4: assert (carry_o == (a_i < b_i));
    if (!sub_i && !use_cin_i)
      assert_add_overflow_R2: assert (carry_o == (res_o < a_i));
    if (sub_i && use_cin_i && cin_i && a_i == b_i)
      assert_sbc_equal_R5: assert (carry_o && half_o && res_o == '1);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = alu8_pkg::ALU_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              half_o
);
  always_comb begin
    unique case (fn_i)
      LG_XOR:  res_o = a_i ^ b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = a_i & b_i;
    endcase
  end

  assign zero_o = ~|res_o;
  assign half_o = (fn_i == LG_AND);

  always_comb begin
    if (fn_i == LG_OR)
      assert_or_cover_R7: assert ((res_o & a_i) == a_i);
  end
endmodule

// File: rtl/alu8_acc_unit.sv
module alu8_acc_unit
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = alu8_pkg::ALU_W,
  parameter int unsigned HALF_W = alu8_pkg::HALF_W
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [7:0]        flags_i,
  input  logic [2:0]        op_sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic [3:0]        flags_o
);
  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] ar_res, lg_res;
  logic              ar_zero, ar_half, ar_carry;
  logic              lg_zero, lg_half;
  logic              carry_in;
  logic              unused_flag_bits;

  assign carry_in         = flags_i[CARRY_BIT];
  assign unused_flag_bits = ^{flags_i[7:CARRY_BIT+1], flags_i[CARRY_BIT-1:0]};

  alu8_op_decode u_dec (
    .op_sel_i (op_sel_i),
    .ctrl_o   (ctrl)
  );

  alu8_arith #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_arith (
    .a_i       (acc_i),
    .b_i       (opnd_i),
    .cin_i     (carry_in),
    .sub_i     (ctrl.sub_mode),
    .use_cin_i (ctrl.use_cin),
    .res_o     (ar_res),
    .zero_o    (ar_zero),
    .half_o    (ar_half),
    .carry_o   (ar_carry)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .fn_i   (ctrl.lfn),
    .res_o  (lg_res),
    .zero_o (lg_zero),
    .half_o (lg_half)
  );

  logic zf, nf, hf, cf;
  always_comb begin
    if (ctrl.use_arith) begin
      zf = ar_zero;
      hf = ar_half;
      cf = ar_carry;
    end else begin
      zf = lg_zero;
      hf = lg_half;
      cf = 1'b0;
    end
    nf = ctrl.sub_mode;
  end

  assign res_we_o = ctrl.write_res;
  assign res_o    = !ctrl.write_res ? acc_i : (ctrl.use_arith ? ar_res : lg_res);
  assign flags_o  = {zf, nf, hf, cf};

  always_comb begin
    if (res_we_o)
      assert_zero_match_R8: assert (flags_o[3] == (res_o == '0));
    if (!res_we_o)
      assert_cmp_keep_acc_R9: assert (res_o == acc_i && flags_o[2]);
    if (op_sel_i == 3'd4)
      assert_and_flags_R6: assert (flags_o[2:0] == 3'b010);
    if (op_sel_i == 3'd5 || op_sel_i == 3'd6)
      assert_xor_or_flags_R7: assert (flags_o[2:0] == 3'b000);
    if (op_sel_i == 3'd0 || op_sel_i == 3'd1)
      assert_add_clears_sub_R2: assert (!flags_o[2] && res_we_o);
  end
endmodule

// File: tb/alu8_acc_unit_tb.sv
module alu8_acc_unit_tb;
  logic       clk = 1'b0;
  logic [7:0] acc, opnd, flg;
  logic [2:0] op;
  logic [7:0] res;
  logic       we;
  logic [3:0] fo;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu8_acc_unit u_dut (
    .acc_i (acc), .opnd_i (opnd), .flags_i (flg), .op_sel_i (op),
    .res_o (res), .res_we_o (we), .flags_o (fo)
  );

  function automatic string tag_of(int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      default: return "R9";
    endcase
  endfunction

  // model: returns {res, we, z, n, h, c}
  function automatic logic [13:0] model(int o, int a, int b, int cin);
    int r, z, n, h, c, w, v;
    r = 0; n = 0; h = 0; c = 0; w = 1;
    case (o)
      0: begin r = a + b; h = ((a % 16) + (b % 16)) > 15; c = r > 255; end
      1: begin r = a + b + cin; h = ((a % 16) + (b % 16) + cin) > 15; c = r > 255; end
      2, 7: begin r = a - b; n = 1; c = a < b; h = (a % 16) < (b % 16); end
      3: begin r = a - b - cin; n = 1; c = a < (b + cin); h = (a % 16) < ((b % 16) + cin); end
      4: begin r = a & b; h = 1; end
      5: r = a ^ b;
      default: r = a | b;
    endcase
    v = (r + 512) % 256;
    z = (v == 0);
    if (o == 7) begin w = 0; v = a; end
    return {v[7:0], w[0], z[0], n[0], h[0], c[0]};
  endfunction

  task automatic apply(int o, int a, int b, int f, string why);
    logic [13:0] exp_v, got;
    @(negedge clk);
    op = 3'(o); acc = 8'(a); opnd = 8'(b); flg = 8'(f);
    #2;
    exp_v = model(o, a, b, (f >> 4) & 1);
    got   = {res, we, fo};
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h f=%02h actual=%04h expected=%04h",
               tag_of(o), why, o, a, b, f, got, exp_v);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_ABCD));
    acc = 0; opnd = 0; flg = 0; op = 0;
    // R1 reset-like idle state: add of zeros gives zero flag, write enabled
    apply(0, 0, 0, 0, "R1 idle add 0+0 R8");
    apply(0, 8'h80, 8'h80, 0, "R2 overflow to zero");
    apply(0, 8'h0F, 8'h01, 0, "R2 nibble carry");
    apply(1, 8'hFF, 8'h00, 8'h10, "R3 carry-in wraps");
    apply(1, 8'h0E, 8'h01, 8'h10, "R3 half from cin");
    apply(2, 8'h10, 8'h01, 0, "R4 half borrow");
    apply(2, 8'h01, 8'h02, 0, "R4 borrow");
    apply(3, 8'h5A, 8'h5A, 8'h10, "R5 A-A-1");
    apply(3, 8'h5A, 8'h5A, 8'h00, "R5 A-A-0 R8");
    apply(4, 8'hF0, 8'h0F, 8'hF0, "R6 and zero");
    apply(5, 8'h3C, 8'h3C, 8'hF0, "R7 xor self");
    apply(6, 8'h00, 8'h00, 8'hF0, "R7 or zero");
    apply(7, 8'h42, 8'h42, 0, "R9 cmp equal");
    apply(7, 8'h40, 8'h41, 0, "R9 cmp low nibble");
    // R10: bits other than carry must not matter
    apply(1, 8'h20, 8'h30, 8'hEF, "R10 other bits set cin=0");
    apply(3, 8'h20, 8'h30, 8'h0F, "R10 low nibble set cin=0");
    apply(0, 8'h77, 8'h99, 8'hFF, "R10 add ignores carry");
    for (int i = 0; i < 4000; i++)
      apply(int'($urandom % 8), int'($urandom % 256), int'($urandom % 256),
            int'($urandom % 256), "random R1");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule